// File: doc/BRIEF.md
# Divider-Setting Search Engine

This block picks the settings of a two-stage clock divider. The first stage divides by a power of two selected by an exponent N (0 to 7). The second stage divides by a linear factor M plus a fixed offset, with M from 0 to 15. A fixed front divide sits ahead of both stages: the parent rate is divided by a pre-divide constant, then by ten. When started, the engine latches a parent rate and a target rate. It then evaluates all 128 (M, N) settings and reports the setting whose output rate is nearest to the target without exceeding it. It also reports that achieved rate.

Each stage of the rate computation truncates, just as the integer arithmetic would. A single iterative divider, one quotient bit per cycle, is shared by the two front divides and by every candidate, so one search takes a few thousand cycles. The result registers change only at the end of a search, and a one-cycle done pulse marks that moment. A start that arrives while a search is running is dropped.

Top module: `clkdiv_search`

## Requirements
- R1: After reset, busy_o and done_o are 0 and best_m_o, best_n_o and best_rate_o are 0.
- R2: A start_i pulse while busy_o is 0 latches parent_rate_i and target_rate_i and raises busy_o on the next cycle. A start_i pulse while busy_o is 1 is ignored: the search in flight completes with the inputs it latched.
- R3: The rate of setting (M, N) is ((parent / PRE_DIV) / 10), shifted right by N, then divided by (M + M_OFFSET), with every step truncating. The defaults are PRE_DIV = 2 and M_OFFSET = 1.
- R4: A setting whose rate is above the target is never reported, so best_rate_o never exceeds the latched target.
- R5: The reported setting has the smallest target minus rate among the settings that qualify. Settings are visited with M as the outer loop (0 to 15) and N as the inner loop (0 to 7), and a later setting replaces the kept one only if its distance is strictly smaller, so the earliest of tied settings wins.
- R6: If no setting has a rate that is both above 0 and at most the target, the result is M = 0, N = 0 and rate 0. This covers a target of 0 and a front rate of 0.
- R7: done_o is high for exactly one cycle after the last setting has been evaluated. In that cycle busy_o is 0 and the result outputs carry the new result. At all other times the result outputs hold their value.
- R8: A start_i pulse in the same cycle as done_o is accepted and begins a new search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; only acted on when idle |
| parent_rate_i | input | 32 | Parent rate, unsigned integer |
| target_rate_i | input | 32 | Requested rate, unsigned integer |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle pulse when a result is published |
| best_m_o | output | 4 | Chosen linear factor setting M |
| best_n_o | output | 3 | Chosen power-of-two exponent N |
| best_rate_o | output | 32 | Rate achieved by the chosen setting |

## Verification
Two events can share a cycle: publishing a result with done_o, and accepting a new start. The bench provokes this by raising start_i at the exact sample where it first sees done_o high. It then checks two things. First, the published values match the first search's reference result. Second, busy_o rises and the second search returns its own reference result. A separate case sends a start with different operands midway through a search, and its result must equal that of the original operands.

// File: rtl/clkdiv_search_pkg.sv
package clkdiv_search_pkg;

    localparam int RATE_W  = 32;
    localparam int M_COUNT = 16;
    localparam int N_COUNT = 8;
    localparam int M_W     = $clog2(M_COUNT);
    localparam int N_W     = $clog2(N_COUNT);

    typedef logic [RATE_W-1:0] rate_t;
    typedef logic [M_W-1:0]    m_t;
    typedef logic [N_W-1:0]    n_t;

    typedef struct packed {
        m_t    m;
        n_t    n;
        rate_t rate;
    } pick_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_DEC,
        PH_SCAN,
        PH_PUBLISH
    } phase_e;

    // True when cand qualifies (not above target) and is strictly closer
    // than the kept rate. kept never exceeds target, so both differences
    // are non-negative.
    function automatic logic closer_under(input rate_t cand,
                                          input rate_t kept,
                                          input rate_t target);
        logic ok;
        ok = (cand <= target) && ((target - cand) < (target - kept));
        return ok;
    endfunction

endpackage

// File: rtl/clkdiv_serial_div.sv
module clkdiv_serial_div
    import clkdiv_search_pkg::*;
#(
    parameter int W = RATE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go_i,
    input  logic [W-1:0] num_i,
    input  logic [W-1:0] den_i,
    output logic         done_o,
    output logic [W-1:0] quo_o
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  quo_q;
    logic [W-1:0]  den_q;
    logic [W:0]    rem_q;
    logic [CW-1:0] cnt_q;
    logic          done_q;
    logic [W:0]    trial;
    logic          fits;

    assign trial = {rem_q[W-1:0], quo_q[W-1]};
    assign fits  = trial >= {1'b0, den_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            quo_q  <= '0;
            den_q  <= '0;
            rem_q  <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (go_i) begin
                quo_q <= num_i;
                den_q <= den_i;
                rem_q <= '0;
                cnt_q <= CW'(W);
            end else if (cnt_q != '0) begin
                if (fits) begin
                    rem_q <= trial - {1'b0, den_q};
                    quo_q <= {quo_q[W-2:0], 1'b1};
                end else begin
                    rem_q <= trial;
                    quo_q <= {quo_q[W-2:0], 1'b0};
                end
                cnt_q <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) begin
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done_o = done_q;
    assign quo_o  = quo_q;

endmodule

// File: rtl/clkdiv_pair_walk.sv
module clkdiv_pair_walk
    import clkdiv_search_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic adv_i,
    output m_t   m_o,
    output n_t   n_o,
    output m_t   m_nxt_o,
    output n_t   n_nxt_o,
    output logic last_o
);
    localparam m_t M_LAST = m_t'(M_COUNT - 1);
    localparam n_t N_LAST = n_t'(N_COUNT - 1);

    m_t m_q;
    n_t n_q;

    // N is the inner loop, M the outer one.
    always_comb begin
        if (n_q == N_LAST) begin
            n_nxt_o = '0;
            m_nxt_o = m_q + m_t'(1);
        end else begin
            n_nxt_o = n_q + n_t'(1);
            m_nxt_o = m_q;
        end
    end

    assign last_o = (m_q == M_LAST) && (n_q == N_LAST);

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            m_q <= '0;
            n_q <= '0;
        end else if (adv_i) begin
            m_q <= m_nxt_o;
            n_q <= n_nxt_o;
        end
    end

    assign m_o = m_q;
    assign n_o = n_q;

endmodule

// File: rtl/clkdiv_best_keep.sv
module clkdiv_best_keep
    import clkdiv_search_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr_i,
    input  logic  upd_i,
    input  rate_t target_i,
    input  m_t    cand_m_i,
    input  n_t    cand_n_i,
    input  rate_t cand_rate_i,
    output pick_t best_o
);
    pick_t best_q;
    logic  take;

    assign take = upd_i && closer_under(cand_rate_i, best_q.rate, target_i);

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            best_q <= '0;
        end else if (take) begin
            best_q.m    <= cand_m_i;
            best_q.n    <= cand_n_i;
            best_q.rate <= cand_rate_i;
        end
    end

    assign best_o = best_q;

endmodule

// File: rtl/clkdiv_search.sv
module clkdiv_search
    import clkdiv_search_pkg::*;
#(
    parameter int unsigned PRE_DIV  = 2,
    parameter int unsigned DECADE   = 10,
    parameter int unsigned M_OFFSET = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [RATE_W-1:0] parent_rate_i,
    input  logic [RATE_W-1:0] target_rate_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [M_W-1:0]    best_m_o,
    output logic [N_W-1:0]    best_n_o,
    output logic [RATE_W-1:0] best_rate_o
);
    localparam rate_t PRE_DEN = rate_t'(PRE_DIV);
    localparam rate_t DEC_DEN = rate_t'(DECADE);
    localparam rate_t OFF_DEN = rate_t'(M_OFFSET);

    phase_e phase_q;
    rate_t  target_q;
    rate_t  base_q;
    pick_t  result_q;
    logic   done_q;

    logic   div_go;
    rate_t  div_num;
    rate_t  div_den;
    logic   div_done;
    rate_t  div_quo;

    logic   walk_clr;
    logic   walk_adv;
    m_t     walk_m;
    n_t     walk_n;
    m_t     walk_m_nxt;
    n_t     walk_n_nxt;
    logic   walk_last;

    logic   keep_clr;
    logic   keep_upd;
    pick_t  keep_best;

    clkdiv_serial_div #(.W(RATE_W)) u_div (
        .clk    (clk),
        .rst    (rst),
        .go_i   (div_go),
        .num_i  (div_num),
        .den_i  (div_den),
        .done_o (div_done),
        .quo_o  (div_quo)
    );

    clkdiv_pair_walk u_walk (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (walk_clr),
        .adv_i   (walk_adv),
        .m_o     (walk_m),
        .n_o     (walk_n),
        .m_nxt_o (walk_m_nxt),
        .n_nxt_o (walk_n_nxt),
        .last_o  (walk_last)
    );

    clkdiv_best_keep u_keep (
        .clk         (clk),
        .rst         (rst),
        .clr_i       (keep_clr),
        .upd_i       (keep_upd),
        .target_i    (target_q),
        .cand_m_i    (walk_m),
        .cand_n_i    (walk_n),
        .cand_rate_i (div_quo),
        .best_o      (keep_best)
    );

    // Sequencing of the shared divider: front divides, then one per setting.
    always_comb begin
        div_go   = 1'b0;
        div_num  = '0;
        div_den  = '0;
        walk_clr = 1'b0;
        walk_adv = 1'b0;
        keep_clr = 1'b0;
        keep_upd = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                if (start_i) begin
                    div_go  = 1'b1;
                    div_num = parent_rate_i;
                    div_den = PRE_DEN;
                end
            end
            PH_PRE: begin
                if (div_done) begin
                    div_go  = 1'b1;
                    div_num = div_quo;
                    div_den = DEC_DEN;
                end
            end
            PH_DEC: begin
                if (div_done) begin
                    div_go   = 1'b1;
                    div_num  = div_quo;
                    div_den  = OFF_DEN;
                    walk_clr = 1'b1;
                    keep_clr = 1'b1;
                end
            end
            PH_SCAN: begin
                if (div_done) begin
                    keep_upd = 1'b1;
                    if (!walk_last) begin
                        walk_adv = 1'b1;
                        div_go   = 1'b1;
                        div_num  = base_q >> walk_n_nxt;
                        div_den  = rate_t'(walk_m_nxt) + OFF_DEN;
                    end
                end
            end
            PH_PUBLISH: begin
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_IDLE;
            target_q <= '0;
            base_q   <= '0;
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (start_i) begin
                        target_q <= target_rate_i;
                        phase_q  <= PH_PRE;
                    end
                end
                PH_PRE: begin
                    if (div_done) begin
                        phase_q <= PH_DEC;
                    end
                end
                PH_DEC: begin
                    if (div_done) begin
                        base_q  <= div_quo;
                        phase_q <= PH_SCAN;
                    end
                end
                PH_SCAN: begin
                    if (div_done && walk_last) begin
                        phase_q <= PH_PUBLISH;
                    end
                end
                PH_PUBLISH: begin
                    result_q <= keep_best;
                    done_q   <= 1'b1;
                    phase_q  <= PH_IDLE;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign busy_o      = (phase_q != PH_IDLE);
    assign done_o      = done_q;
    assign best_m_o    = result_q.m;
    assign best_n_o    = result_q.n;
    assign best_rate_o = result_q.rate;

endmodule

// File: rtl/clkdiv_search_chk.sv
module clkdiv_search_chk
    import clkdiv_search_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [M_W-1:0]    best_m_o,
    input logic [N_W-1:0]    best_n_o,
    input logic [RATE_W-1:0] best_rate_o,
    input logic [RATE_W-1:0] target_q
);
    // R7: done lasts a single cycle
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R7: results move only together with done
    assert_result_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable({best_m_o, best_n_o, best_rate_o}));

    // R7: engine is idle when it publishes
    assert_idle_at_done_R7: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    // R4: published rate never exceeds the latched target
    assert_under_target_R4: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (best_rate_o <= target_q));

    // R6: a zero rate comes only with the zero setting
    assert_empty_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (done_o && best_rate_o == '0) |-> (best_m_o == '0 && best_n_o == '0));

    // R2: a start while busy does not reload the target
    assert_busy_start_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> $stable(target_q));

endmodule

bind clkdiv_search clkdiv_search_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .best_m_o    (best_m_o),
    .best_n_o    (best_n_o),
    .best_rate_o (best_rate_o),
    .target_q    (target_q)
);

// File: tb/clkdiv_search_test.sv
module clkdiv_search_test;

    localparam int unsigned PRE  = 2;
    localparam int unsigned OFFS = 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] parent_rate_i = '0;
    logic [31:0] target_rate_i = '0;
    logic        busy_o;
    logic        done_o;
    logic [3:0]  best_m_o;
    logic [2:0]  best_n_o;
    logic [31:0] best_rate_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    clkdiv_search uut (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start_i),
        .parent_rate_i (parent_rate_i),
        .target_rate_i (target_rate_i),
        .busy_o        (busy_o),
        .done_o        (done_o),
        .best_m_o      (best_m_o),
        .best_n_o      (best_n_o),
        .best_rate_o   (best_rate_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles, expected under 190000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input logic ok, input string req, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reference search written from the requirements.
    task automatic model(input logic [31:0] parent, input logic [31:0] target,
                         output logic [3:0] em, output logic [2:0] en,
                         output logic [31:0] er);
        logic [31:0] base;
        logic [31:0] r;
        base = (parent / PRE) / 10;
        em = '0; en = '0; er = '0;
        for (int m = 0; m < 16; m++) begin
            for (int n = 0; n < 8; n++) begin
                r = (base >> n) / (m + OFFS);
                if (r <= target && (target - r) < (target - er)) begin
                    er = r; em = 4'(m); en = 3'(n);
                end
            end
        end
    endtask

    task automatic pulse_start(input logic [31:0] p, input logic [31:0] t);
        parent_rate_i = p;
        target_rate_i = t;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done_o && n < 10000) begin
            @(negedge clk);
            n++;
        end
        check(done_o, req, longint'(done_o), 1);
    endtask

    task automatic compare(input logic [31:0] p, input logic [31:0] t, input string req);
        logic [3:0] em; logic [2:0] en; logic [31:0] er;
        model(p, t, em, en, er);
        check(best_m_o == em, {req, " M"}, best_m_o, em);
        check(best_n_o == en, {req, " N"}, best_n_o, en);
        check(best_rate_o == er, {req, " rate"}, best_rate_o, er);
    endtask

    task automatic run_search(input logic [31:0] p, input logic [31:0] t, input string req);
        @(negedge clk);
        pulse_start(p, t);
        check(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
        wait_done({req, " done"});
        check(busy_o == 1'b0, "R7 idle at done", busy_o, 0);
        compare(p, t, req);
        @(negedge clk);
        check(done_o == 1'b0, "R7 done single cycle", done_o, 0);
        compare(p, t, {req, " R7 held"});
    endtask

    task automatic test_reset();
        check(busy_o == 1'b0, "R1 busy", busy_o, 0);
        check(done_o == 1'b0, "R1 done", done_o, 0);
        check(best_rate_o == '0 && best_m_o == '0 && best_n_o == '0,
              "R1 result", best_rate_o, 0);
    endtask

    task automatic test_tie();
        // base 8: (M0,N1) and (M1,N0) both give 4; earliest is (0,1)
        run_search(32'd160, 32'd5, "R5 tie");
        check(best_m_o == 4'd0 && best_n_o == 3'd1, "R5 earliest tie",
              {best_m_o, best_n_o}, {4'd0, 3'd1});
    endtask

    task automatic test_ignored_start();
        @(negedge clk);
        pulse_start(32'd24_000_000, 32'd333_333);
        repeat (300) @(negedge clk);
        pulse_start(32'd1000, 32'd7);
        check(busy_o == 1'b1, "R2 still busy", busy_o, 1);
        wait_done("R2 ignored done");
        compare(32'd24_000_000, 32'd333_333, "R2 ignored start");
        @(negedge clk);
    endtask

    task automatic test_start_on_done();
        @(negedge clk);
        pulse_start(32'd48_000_000, 32'd250_000);
        wait_done("R8 first done");
        compare(32'd48_000_000, 32'd250_000, "R8 first");
        pulse_start(32'd5_000_000, 32'd12_345);
        check(busy_o == 1'b1, "R8 restart accepted", busy_o, 1);
        wait_done("R8 second done");
        compare(32'd5_000_000, 32'd12_345, "R8 second");
        @(negedge clk);
    endtask

    task automatic test_sweep();
        logic [31:0] lf = 32'hACE1_2468;
        for (int i = 0; i < 4; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            run_search(lf, lf >> (8 + i * 2), "R3 sweep");
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        run_search(32'd24_000_000, 32'd100_000, "R3 typical");
        run_search(32'd24_000_000, 32'd1_200_000, "R5 exact at M0 N0");
        run_search(32'd2019, 32'd33, "R3 truncation");
        run_search(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4 max target");
        check(best_rate_o == 32'd214748364, "R3 max rate", best_rate_o, 214748364);
        run_search(32'd24_000_000, 32'd0, "R6 zero target");
        check(best_rate_o == '0, "R6 zero rate", best_rate_o, 0);
        run_search(32'd19, 32'd50, "R6 zero base");
        run_search(32'd1_000_000, 32'd3, "R4 tiny target");
        test_tie();
        test_ignored_start();
        test_start_on_done();
        test_sweep();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule